// File: doc/BRIEF.md
# In-Order Retirement Buffer with Instruction-Atomic Commit

This block tracks in-flight micro-operations of an out-of-order core in a circular buffer of 40 entries. The front end allocates up to three uops per cycle in program order, each uop marked with whether it ends its parent instruction. Execution units report completion with the entry index and the result. The block retires completed uops strictly from the oldest end, at most three per cycle. Each retired uop appears on retire outputs that drive the write port of the architectural register file and tell the rename table which entry index has been released.

An instruction made of several uops is never committed in part. The retire window is cut after the last complete instruction that fits in the three slots, and an instruction that does not fit waits for a later cycle. Retirement is a three-stage pipeline from candidate selection to the commit outputs. A mispredicted branch flushes every entry younger than the branch, and the tail pointer moves back to the slot just after the branch.

Top module: `rob_atomic_retire`

## Requirements
- R1: The buffer holds 40 entries. `alloc_ok` is high exactly when the free entry count is at least `alloc_cnt`. When `alloc_ok` is low, nothing is allocated and `alloc_tail` does not change.
- R2: An accepted allocation of `alloc_cnt` uops takes consecutive indices starting at `alloc_tail`, wrapping from 39 to 0. Slot k of the alloc inputs gets index `alloc_tail`+k, and `alloc_tail` advances by `alloc_cnt`.
- R3: A writeback with `wb_vld[w]` set marks entry `wb_tag[w]` complete and stores `wb_data[w]` as its result. Completion may arrive in any order.
- R4: Uops retire in allocation order, at most three per cycle. Retire slot 0 is the oldest, and valid slots are contiguous from slot 0 with consecutive indices. No uop retires while an older one is incomplete.
- R5: `alloc_eop` set marks the last uop of an instruction. A retire group always ends on such a uop. An instruction that has any incomplete uop, or that does not fit in the slots left in the group, retires whole in a later cycle.
- R6: If the oldest instruction's last missing completion is written on clock edge E, its uops appear on the retire outputs for exactly one cycle, starting at edge E+3.
- R7: Each retiring uop presents its entry index on `ret_tag`, its destination register on `ret_areg`, its write enable on `ret_we` and its result on `ret_data`.
- R8: On `flush_vld`, every entry younger than `flush_tag` is discarded and never retires. `alloc_tail` becomes `flush_tag`+1 (mod 40). Older entries and the branch itself retire normally, and the freed indices are reused by later allocations with their new contents.
- R9: In a flush cycle, no retire group is selected (selection resumes the next cycle) and any offered allocation is ignored.
- R10: After reset the buffer is empty, `alloc_tail` is 0, no retire slot is valid, and `alloc_ok` is high for an offer of three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 2 | Number of uops offered this cycle (0 to 3) |
| alloc_areg | input | 3x5 | Destination architectural register per alloc slot |
| alloc_we | input | 3 | Register-write enable per alloc slot |
| alloc_eop | input | 3 | Last uop of its instruction, per alloc slot |
| alloc_ok | output | 1 | Enough free entries for the offer |
| alloc_tail | output | 6 | Index given to alloc slot 0 |
| wb_vld | input | 2 | Completion strobe per writeback port |
| wb_tag | input | 2x6 | Entry index per writeback port |
| wb_data | input | 2x32 | Result per writeback port |
| flush_vld | input | 1 | Mispredicted branch flush |
| flush_tag | input | 6 | Entry index of the mispredicted branch |
| ret_vld | output | 3 | Retire slot valid |
| ret_tag | output | 3x6 | Released entry index per retire slot |
| ret_areg | output | 3x5 | Register to write per retire slot |
| ret_we | output | 3 | Register-write enable per retire slot |
| ret_data | output | 3x32 | Result per retire slot |

## Verification
A flush can arrive in the same cycle in which a completed instruction at the head would be picked for retirement, and in the same cycle as an allocation offer. The bench completes the oldest uop and asserts a flush on a younger, incomplete entry in the very next cycle while also offering two uops. It then judges the outcome in two ways. The completed uop must commit one cycle later than its normal three-cycle latency. The tail must land just after the flushed branch, with the offered uops absent.

// File: rtl/rob_atomic_retire.sv
module rob_atomic_retire #(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int WB_W    = 2,
  parameter int DATA_W  = 32,
  parameter int AREG_W  = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ACNT_W = $clog2(ALLOC_W + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ACNT_W-1:0]                alloc_cnt,
  input  logic [ALLOC_W-1:0][AREG_W-1:0]   alloc_areg,
  input  logic [ALLOC_W-1:0]               alloc_we,
  input  logic [ALLOC_W-1:0]               alloc_eop,
  output logic                             alloc_ok,
  output logic [IDX_W-1:0]                 alloc_tail,
  input  logic [WB_W-1:0]                  wb_vld,
  input  logic [WB_W-1:0][IDX_W-1:0]       wb_tag,
  input  logic [WB_W-1:0][DATA_W-1:0]      wb_data,
  input  logic                             flush_vld,
  input  logic [IDX_W-1:0]                 flush_tag,
  output logic [RET_W-1:0]                 ret_vld,
  output logic [RET_W-1:0][IDX_W-1:0]      ret_tag,
  output logic [RET_W-1:0][AREG_W-1:0]     ret_areg,
  output logic [RET_W-1:0]                 ret_we,
  output logic [RET_W-1:0][DATA_W-1:0]     ret_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(RET_W + 1);
  localparam int LAT   = 3;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count, free_n, keep_n;
  logic [DEPTH-1:0]  done, eop, we;
  logic [AREG_W-1:0] areg [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  logic              alloc_fire;

  logic [RET_W-1:0][IDX_W-1:0] sidx;
  logic [SEL_W-1:0]            sel_n;

  logic [RET_W-1:0]              p_vld  [LAT];
  logic [RET_W-1:0]              p_eop  [LAT];
  logic [RET_W-1:0]              p_we   [LAT];
  logic [RET_W-1:0][IDX_W-1:0]   p_tag  [LAT];
  logic [RET_W-1:0][AREG_W-1:0]  p_areg [LAT];
  logic [RET_W-1:0][DATA_W-1:0]  p_data [LAT];

  assign free_n     = DEPTH_C - count;
  assign alloc_ok   = free_n >= CNT_W'(alloc_cnt);
  assign alloc_fire = alloc_ok && !flush_vld && (alloc_cnt != '0);
  assign alloc_tail = tail;
  assign keep_n     = (flush_tag >= head) ? CNT_W'(flush_tag - head) + ONE_C
                                          : DEPTH_C - CNT_W'(head) + CNT_W'(flush_tag) + ONE_C;

  always_comb begin
    logic pre;
    pre   = 1'b1;
    sel_n = '0;
    for (int k = 0; k < RET_W; k++) begin
      sidx[k] = wrap_add(head, k);
      pre = pre && (CNT_W'(k) < count) && done[sidx[k]];
      if (pre && eop[sidx[k]]) sel_n = SEL_W'(k + 1);
    end
    if (flush_vld) sel_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      done  <= '0;
      eop   <= '0;
      we    <= '0;
    end else begin
      for (int w = 0; w < WB_W; w++)
        if (wb_vld[w]) done[wb_tag[w]] <= 1'b1;
      if (flush_vld) begin
        tail  <= wrap_add(flush_tag, 1);
        count <= keep_n;
      end else begin
        head  <= wrap_add(head, int'(sel_n));
        count <= count - CNT_W'(sel_n) + (alloc_fire ? CNT_W'(alloc_cnt) : '0);
        if (alloc_fire) begin
          tail <= wrap_add(tail, int'(alloc_cnt));
          for (int k = 0; k < ALLOC_W; k++)
            if (k < int'(alloc_cnt)) begin
              done[wrap_add(tail, k)] <= 1'b0;
              eop[wrap_add(tail, k)]  <= alloc_eop[k];
              we[wrap_add(tail, k)]   <= alloc_we[k];
            end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WB_W; w++)
      if (wb_vld[w]) data[wb_tag[w]] <= wb_data[w];
    if (alloc_fire)
      for (int k = 0; k < ALLOC_W; k++)
        if (k < int'(alloc_cnt)) areg[wrap_add(tail, k)] <= alloc_areg[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        p_vld[s]  <= '0;
        p_eop[s]  <= '0;
        p_we[s]   <= '0;
        p_tag[s]  <= '0;
        p_areg[s] <= '0;
        p_data[s] <= '0;
      end
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        p_vld[0][k]  <= k < int'(sel_n);
        p_eop[0][k]  <= eop[sidx[k]];
        p_we[0][k]   <= we[sidx[k]];
        p_tag[0][k]  <= sidx[k];
        p_areg[0][k] <= areg[sidx[k]];
        p_data[0][k] <= data[sidx[k]];
      end
      for (int s = 1; s < LAT; s++) begin
        p_vld[s]  <= p_vld[s-1];
        p_eop[s]  <= p_eop[s-1];
        p_we[s]   <= p_we[s-1];
        p_tag[s]  <= p_tag[s-1];
        p_areg[s] <= p_areg[s-1];
        p_data[s] <= p_data[s-1];
      end
    end
  end

  assign ret_vld  = p_vld[LAT-1];
  assign ret_tag  = p_tag[LAT-1];
  assign ret_areg = p_areg[LAT-1];
  assign ret_we   = p_we[LAT-1];
  assign ret_data = p_data[LAT-1];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ok && !flush_vld) |=> (tail == $past(tail))); // R1
  AST_GROUP_ENDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_vld & ~(ret_vld >> 1) & ~p_eop[LAT-1]) == '0)); // R5
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |=> (tail == wrap_add($past(flush_tag), 1))); // R8
  AST_FLUSH_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |=> (p_vld[0] == '0)); // R9

  for (genvar gk = 1; gk < RET_W; gk++) begin : g_ord
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ret_vld[gk] |-> (ret_vld[gk-1] && ret_tag[gk] == wrap_add(ret_tag[gk-1], 1))); // R4
  end
endmodule

// File: tb/rob_atomic_retire_tb.sv
module rob_atomic_retire_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]       alloc_cnt = '0;
  logic [2:0][4:0]  alloc_areg = '0;
  logic [2:0]       alloc_we = '0;
  logic [2:0]       alloc_eop = '0;
  logic             alloc_ok;
  logic [5:0]       alloc_tail;
  logic [1:0]       wb_vld = '0;
  logic [1:0][5:0]  wb_tag = '0;
  logic [1:0][31:0] wb_data = '0;
  logic             flush_vld = 1'b0;
  logic [5:0]       flush_tag = '0;
  logic [2:0]       ret_vld;
  logic [2:0][5:0]  ret_tag;
  logic [2:0][4:0]  ret_areg;
  logic [2:0]       ret_we;
  logic [2:0][31:0] ret_data;

  rob_atomic_retire u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_cnt(alloc_cnt), .alloc_areg(alloc_areg), .alloc_we(alloc_we), .alloc_eop(alloc_eop),
    .alloc_ok(alloc_ok), .alloc_tail(alloc_tail),
    .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
    .flush_vld(flush_vld), .flush_tag(flush_tag),
    .ret_vld(ret_vld), .ret_tag(ret_tag), .ret_areg(ret_areg), .ret_we(ret_we), .ret_data(ret_data)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int lg_tag [512];
  int lg_data [512];
  int lg_areg [512];
  int lg_cyc [512];
  int lg_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n)
      for (int k = 0; k < 3; k++)
        if (ret_vld[k] && lg_n < 512) begin
          lg_tag[lg_n]  = int'(ret_tag[k]);
          lg_data[lg_n] = int'(ret_data[k]);
          lg_areg[lg_n] = int'(ret_areg[k]);
          lg_cyc[lg_n]  = cyc;
          lg_n = lg_n + 1;
        end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    alloc_cnt = '0;
    wb_vld = '0;
    flush_vld = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic do_alloc(int n, logic [2:0] eops, int areg0);
    alloc_cnt = 2'(n);
    alloc_eop = eops;
    alloc_we = 3'b111;
    for (int k = 0; k < 3; k++) alloc_areg[k] = 5'(areg0 + k);
    tick();
  endtask

  task automatic do_wb1(int t, int d);
    wb_vld = 2'b01;
    wb_tag[0] = 6'(t);
    wb_data[0] = 32'(d);
    tick();
  endtask

  task automatic do_wb2(int t0, int d0, int t1, int d1);
    wb_vld = 2'b11;
    wb_tag[0] = 6'(t0);
    wb_data[0] = 32'(d0);
    wb_tag[1] = 6'(t1);
    wb_data[1] = 32'(d1);
    tick();
  endtask

  task automatic t_reset();
    chk("R10 ret_vld", int'(ret_vld), 0);
    chk("R10 alloc_tail", int'(alloc_tail), 0);
    alloc_cnt = 2'd3;
    #1;
    chk("R10 alloc_ok", int'(alloc_ok), 1);
    alloc_cnt = '0;
  endtask

  task automatic t_in_order();
    int base, t0;
    base = lg_n;
    do_alloc(3, 3'b111, 1);
    do_wb1(2, 'h102);
    do_wb1(1, 'h101);
    idle(5);
    chk("R4 no retire past incomplete oldest", lg_n, base);
    t0 = cyc;
    do_wb1(0, 'h100);
    idle(6);
    chk("R4 group size", lg_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 tag order", lg_tag[base+i], i);
      chk("R3 result", lg_data[base+i], 'h100 + i);
      chk("R7 areg", lg_areg[base+i], 1 + i);
      chk("R6 latency", lg_cyc[base+i], t0 + 4);
    end
  endtask

  task automatic t_atomic();
    int base, tc;
    base = lg_n;
    do_alloc(3, 3'b001, 10);
    do_alloc(1, 3'b001, 13);
    do_wb2(3, 'h103, 4, 'h104);
    do_wb1(5, 'h105);
    idle(6);
    chk("R5 partial instr held", lg_n - base, 1);
    chk("R5 single retired", lg_tag[base], 3);
    do_wb1(6, 'h106);
    idle(6);
    chk("R5 whole instr count", lg_n - base, 4);
    for (int i = 1; i < 4; i++) begin
      chk("R5 whole instr tag", lg_tag[base+i], 3 + i);
      chk("R5 whole instr same cycle", lg_cyc[base+i], lg_cyc[base+1]);
    end
    base = lg_n;
    do_alloc(3, 3'b001, 20);
    do_alloc(1, 3'b001, 23);
    do_wb2(8, 'h108, 9, 'h109);
    do_wb1(10, 'h10a);
    tc = cyc;
    do_wb1(7, 'h107);
    idle(7);
    chk("R5 cut count", lg_n - base, 4);
    chk("R5 cut first tag", lg_tag[base], 7);
    chk("R5 cut first cycle", lg_cyc[base], tc + 4);
    for (int i = 1; i < 4; i++) begin
      chk("R5 cut later tag", lg_tag[base+i], 7 + i);
      chk("R5 cut later cycle", lg_cyc[base+i], tc + 5);
    end
  endtask

  task automatic t_full_wrap();
    int base;
    base = lg_n;
    repeat (13) do_alloc(3, 3'b111, 0);
    chk("R2 tail wrap", int'(alloc_tail), 10);
    alloc_cnt = 2'd3;
    alloc_eop = 3'b111;
    #1;
    chk("R1 stall on 3 with 1 free", int'(alloc_ok), 0);
    tick();
    chk("R1 tail held on stall", int'(alloc_tail), 10);
    alloc_cnt = 2'd1;
    #1;
    chk("R1 accept 1 with 1 free", int'(alloc_ok), 1);
    tick();
    chk("R2 tail after last slot", int'(alloc_tail), 11);
    alloc_cnt = 2'd1;
    #1;
    chk("R1 full stall", int'(alloc_ok), 0);
    tick();
    for (int i = 0; i < 20; i++)
      do_wb2((11 + 2*i) % 40, 'h200 + 2*i, (12 + 2*i) % 40, 'h201 + 2*i);
    idle(8);
    chk("R1 drained 40", lg_n - base, 40);
    for (int i = 0; i < 40; i++) begin
      chk("R2 wrap order", lg_tag[base+i], (11 + i) % 40);
      chk("R3 wrap data", lg_data[base+i], 'h200 + i);
    end
  endtask

  task automatic t_flush();
    int base;
    base = lg_n;
    do_alloc(3, 3'b111, 1);
    do_alloc(3, 3'b111, 4);
    do_wb2(14, 'h314, 15, 'h315);
    flush_vld = 1'b1;
    flush_tag = 6'd12;
    tick();
    chk("R8 tail after flush", int'(alloc_tail), 13);
    do_wb2(11, 'h311, 12, 'h312);
    idle(8);
    chk("R8 only older and branch", lg_n - base, 2);
    chk("R8 older tag", lg_tag[base], 11);
    chk("R8 branch tag", lg_tag[base+1], 12);
    do_alloc(1, 3'b001, 9);
    chk("R8 reuse tail", int'(alloc_tail), 14);
    do_wb1(13, 'h3ab);
    idle(6);
    chk("R8 reuse count", lg_n - base, 3);
    chk("R8 reuse tag", lg_tag[base+2], 13);
    chk("R8 reuse data", lg_data[base+2], 'h3ab);
    chk("R8 reuse areg", lg_areg[base+2], 9);
  endtask

  task automatic t_flush_same_cycle();
    int base, t0;
    base = lg_n;
    do_alloc(3, 3'b111, 1);
    t0 = cyc;
    do_wb1(14, 'h414);
    flush_vld = 1'b1;
    flush_tag = 6'd15;
    alloc_cnt = 2'd2;
    alloc_eop = 3'b111;
    tick();
    chk("R9 alloc ignored in flush", int'(alloc_tail), 16);
    idle(6);
    chk("R9 one retire", lg_n - base, 1);
    chk("R9 tag", lg_tag[base], 14);
    chk("R9 delayed by flush", lg_cyc[base], t0 + 5);
    do_wb1(15, 'h415);
    idle(6);
    chk("R8 branch retires", lg_n - base, 2);
    do_wb1(16, 'h416);
    idle(6);
    chk("R8 flushed entry never retires", lg_n - base, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_atomic();
    t_full_wrap();
    t_flush();
    t_flush_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule